// File: doc/BRIEF.md
# CAN Receive Bit Recovery

This block turns one oversampled, already-synchronised CAN receive line into a stream of logical frame bits. It sits on an idle recessive bus and waits. The first dominant sample marks the frame start. From that point every raw bit is sampled at a fixed cycle position inside its bit period. That position comes from a clocks-per-bit setting and a sample-point percentage. Timing is anchored to the frame-start edge only. No later edge moves the sampling grid.

Each raw sample is passed through a destuffer that looks back over the last six raw samples. If the window reads five equal bits followed by the opposite level, the newest sample is a stuff bit. A stuff bit produces a one-cycle stuff pulse and is not delivered. Every other sample comes out with a valid strobe, its level, and a destuffed index in which the start-of-frame bit is 0.

A frame-layer decoder downstream recognises the end of the frame and pulses the restart input. That pulse returns the block to waiting.

The controller has two states. ST_IDLE waits for a dominant sample. ST_RUN samples raw bits. It has three transitions:
- ST_IDLE to ST_RUN on a dominant sample with no restart.
- ST_RUN to ST_IDLE on restart.
- Every other case holds the current state.

Top module: `can_bit_recovery`

## Requirements
- R1: In ST_IDLE a recessive (1) line is ignored: the state stays ST_IDLE and neither bit_valid_o nor stuff_o pulses.
- R2: In ST_IDLE, a clock edge that sees rx_i = 0 with restart_i = 0 moves the block to ST_RUN. That edge is the frame start E0. If restart_i = 1 at that edge, the block stays in ST_IDLE.
- R3: Raw bit n (n = 0 for the start-of-frame bit) is sampled at clock edge E0 + n*P + O, where P is the bit period and O the sample offset. The result appears on the outputs as a one-cycle pulse in the cycle that follows that edge.
- R4: O is floor(P * sample_pct_i / 100), raised to 1 when the product gives 0. The inputs must satisfy P >= 2 and O < P.
- R5: P and O are captured at E0. Changes to bit_cycles_i or sample_pct_i during a frame do not move that frame's sample points.
- R6: When at least six raw samples have been taken and the newest six, oldest first, read 000001 or 111110, the newest sample is a stuff bit. stuff_o pulses for one cycle and bit_valid_o stays 0. Six equal samples are not a stuff bit and are delivered as data.
- R7: Stuff bits remain in the raw history, so a stuff bit counts as the first bit of the next run of equal levels.
- R8: Each non-stuff sample gives a one-cycle bit_valid_o, with bit_value_o equal to the sampled level and bit_index_o equal to its destuffed index. The index starts at 0 for each frame, rises by 1 per data bit, and does not advance on stuff bits.
- R9: restart_i returns the block to ST_IDLE on the next edge. It clears the raw history, the fill count and the index. No sample is taken at that edge, and no output pulses until a new frame starts.
- R10: While reset (rst_n = 0) is held, bit_valid_o, stuff_o, bit_value_o and bit_index_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_i | input | 1 | Synchronised receive line, 0 = dominant |
| bit_cycles_i | input | CYC_W | Clock cycles per bit (P) |
| sample_pct_i | input | PCT_W | Sample point, percent of the bit period |
| restart_i | input | 1 | Frame-done pulse; returns the block to idle |
| bit_valid_o | output | 1 | One-cycle strobe for a delivered data bit |
| bit_value_o | output | 1 | Level of the delivered bit |
| bit_index_o | output | IDX_W | Destuffed bit index, start-of-frame = 0 |
| stuff_o | output | 1 | One-cycle pulse when a stuff bit is recognised |

## Verification
The bench checks that a stuff bit is counted as the start of the following run. A design that cleared its history after destuffing would deliver the second stuff bit of the 00000 1 1111 0 pattern as data, and every later index would be off by one.

It also restarts after a frame that ends in dominant bits and then sends a frame whose opening bits would complete a stale stuff window. A block that kept old history would flag a false stuff bit there.

Sample edges are checked to the exact cycle under several period and percentage pairs. These include a pair whose floor is 0, so a wrong rounding or a missing clamp shows up as a shifted edge. The bench also changes the period in mid-frame, which catches a design that reads the live setting instead of the captured one.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_t;

    // Raw samples examined by the destuffer.
    localparam int HIST_LEN = 6;

endpackage

// File: rtl/can_rx_timer.sv
module can_rx_timer #(
    parameter int CYC_W = 16,
    parameter int PCT_W = 7,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic [CYC_W-1:0] bit_cycles_i,
    input  logic [PCT_W-1:0] sample_pct_i,
    output logic             hit_o
);

    localparam int PROD_W = CYC_W + PCT_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;
    logic [CYC_W-1:0]  off_calc;
    logic [CYC_W-1:0]  per_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  tgt_q;

    // Offset is floor(period * pct / 100), never below one cycle.
    always_comb begin
        prod     = PROD_W'(bit_cycles_i) * PROD_W'(sample_pct_i);
        quo      = prod / PROD_W'(100);
        off_calc = (quo == '0) ? CYC_W'(1) : CYC_W'(quo);
    end

    assign hit_o = run_i && (cnt_q == tgt_q);

    // The next target is accumulated one period at a time, so no multiplier
    // sits in the compare path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= '0;
            cnt_q <= '0;
            tgt_q <= '0;
        end else if (start_i) begin
            per_q <= bit_cycles_i;
            cnt_q <= CNT_W'(1);
            tgt_q <= CNT_W'(off_calc);
        end else if (run_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (hit_o) begin
                tgt_q <= tgt_q + CNT_W'(per_q);
            end
        end
    end

endmodule

// File: rtl/can_rx_destuff.sv
module can_rx_destuff
    import can_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic take_i,
    input  logic rx_i,
    output logic stuff_o
);

    localparam int FILL_W = $clog2(HIST_LEN);
    localparam logic [HIST_LEN-1:0] PAT_LOW  = {{(HIST_LEN-1){1'b0}}, 1'b1};
    localparam logic [HIST_LEN-1:0] PAT_HIGH = {{(HIST_LEN-1){1'b1}}, 1'b0};

    logic [HIST_LEN-2:0] hist_q;
    logic [FILL_W-1:0]   fill_q;
    logic [HIST_LEN-1:0] win;
    logic                full;

    // The window is the stored samples, oldest first, followed by the new one.
    assign win     = {hist_q, rx_i};
    assign full    = (fill_q == FILL_W'(HIST_LEN - 1));
    assign stuff_o = full && ((win == PAT_LOW) || (win == PAT_HIGH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (clear_i) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (take_i) begin
            hist_q <= win[HIST_LEN-2:0];
            if (!full) begin
                fill_q <= fill_q + FILL_W'(1);
            end
        end
    end

endmodule

// File: rtl/can_rx_fsm.sv
module can_rx_fsm
    import can_rx_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             restart_i,
    input  logic             take_i,
    input  logic             stuff_i,
    output state_t           state_o,
    output logic             start_o,
    output logic             run_o,
    output logic             bit_valid_o,
    output logic             bit_value_o,
    output logic [IDX_W-1:0] bit_index_o,
    output logic             stuff_o
);

    state_t           state_q;
    state_t           state_d;
    logic [IDX_W-1:0] idx_q;

    assign state_o = state_q;
    assign run_o   = (state_q == ST_RUN);

    always_comb begin
        state_d = state_q;
        start_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!rx_i && !restart_i) begin
                    start_o = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (restart_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_valid_o <= 1'b0;
            bit_value_o <= 1'b0;
            bit_index_o <= '0;
            stuff_o     <= 1'b0;
            idx_q       <= '0;
        end else begin
            bit_valid_o <= 1'b0;
            stuff_o     <= 1'b0;
            if (restart_i || start_o) begin
                idx_q <= '0;
            end else if (take_i) begin
                if (stuff_i) begin
                    stuff_o <= 1'b1;
                end else begin
                    bit_valid_o <= 1'b1;
                    bit_value_o <= rx_i;
                    bit_index_o <= idx_q;
                    idx_q       <= idx_q + IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/can_bit_recovery.sv
module can_bit_recovery
    import can_rx_pkg::*;
#(
    parameter int CYC_W   = 16,
    parameter int PCT_W   = 7,
    parameter int MAX_RAW = 256,
    parameter int IDX_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic [CYC_W-1:0] bit_cycles_i,
    input  logic [PCT_W-1:0] sample_pct_i,
    input  logic             restart_i,
    output logic             bit_valid_o,
    output logic             bit_value_o,
    output logic [IDX_W-1:0] bit_index_o,
    output logic             stuff_o
);

    localparam int CNT_W = CYC_W + $clog2(MAX_RAW);

    state_t state;
    logic   start;
    logic   run;
    logic   hit;
    logic   take;
    logic   is_stuff;

    // No sample is taken on the edge that restarts the block.
    assign take = hit && !restart_i;

    can_rx_timer #(
        .CYC_W (CYC_W),
        .PCT_W (PCT_W),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .run_i        (run),
        .bit_cycles_i (bit_cycles_i),
        .sample_pct_i (sample_pct_i),
        .hit_o        (hit)
    );

    can_rx_destuff u_destuff (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (restart_i),
        .take_i  (take),
        .rx_i    (rx_i),
        .stuff_o (is_stuff)
    );

    can_rx_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_i        (rx_i),
        .restart_i   (restart_i),
        .take_i      (take),
        .stuff_i     (is_stuff),
        .state_o     (state),
        .start_o     (start),
        .run_o       (run),
        .bit_valid_o (bit_valid_o),
        .bit_value_o (bit_value_o),
        .bit_index_o (bit_index_o),
        .stuff_o     (stuff_o)
    );

endmodule

// File: rtl/can_rx_chk.sv
module can_rx_chk
    import can_rx_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_i,
    input logic             restart_i,
    input state_t           state,
    input logic             bit_valid_o,
    input logic [IDX_W-1:0] bit_index_o,
    input logic             stuff_o
);

    logic [IDX_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (state == ST_IDLE) begin
            seen_q <= '0;
        end else if (bit_valid_o) begin
            seen_q <= seen_q + IDX_W'(1);
        end
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rx_i) |=> (state == ST_IDLE));

    // R2
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !rx_i && !restart_i) |=> (state == ST_RUN));

    // R3
    out_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_o || stuff_o) |-> ($past(state) == ST_RUN));

    // R6
    stuff_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid_o && stuff_o));

    // R8
    index_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> (bit_index_o == seen_q));

    // R9
    restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (state == ST_IDLE && !bit_valid_o && !stuff_o));

endmodule

bind can_bit_recovery can_rx_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_i        (rx_i),
    .restart_i   (restart_i),
    .state       (state),
    .bit_valid_o (bit_valid_o),
    .bit_index_o (bit_index_o),
    .stuff_o     (stuff_o)
);

// File: tb/can_bit_recovery_bench.sv
`timescale 1ns/1ps
module can_bit_recovery_bench;

    localparam int CYC_W = 16;
    localparam int PCT_W = 7;
    localparam int IDX_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rx;
    logic [CYC_W-1:0] bit_cycles;
    logic [PCT_W-1:0] sample_pct;
    logic             restart;
    logic             bit_valid_o;
    logic             bit_value_o;
    logic [IDX_W-1:0] bit_index_o;
    logic             stuff_o;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    int e0       = 0;

    logic raw_q [64];
    int   raw_len = 0;

    int   ev_cnt = 0;
    int   ev_edge  [128];
    logic ev_val   [128];
    logic ev_stuff [128];
    int   ev_idx   [128];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    can_bit_recovery #(
        .CYC_W (CYC_W),
        .PCT_W (PCT_W),
        .IDX_W (IDX_W)
    ) u_can_bit_recovery (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_i         (rx),
        .bit_cycles_i (bit_cycles),
        .sample_pct_i (sample_pct),
        .restart_i    (restart),
        .bit_valid_o  (bit_valid_o),
        .bit_value_o  (bit_value_o),
        .bit_index_o  (bit_index_o),
        .stuff_o      (stuff_o)
    );

    // Records every output pulse together with the edge that produced it.
    always @(negedge clk) begin
        if (rst_n && (bit_valid_o || stuff_o) && ev_cnt < 128) begin
            ev_edge[ev_cnt]  = cyc;
            ev_val[ev_cnt]   = bit_value_o;
            ev_stuff[ev_cnt] = stuff_o;
            ev_idx[ev_cnt]   = int'(bit_index_o);
            ev_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] pat, input int len);
        for (int i = 0; i < len; i++) raw_q[i] = pat[len-1-i];
        raw_len = len;
    endtask

    // Drives raw_q bit by bit, then pulses restart one edge after the last bit.
    task automatic run_frame(input int per, input int pct, input int alt);
        bit_cycles = CYC_W'(per);
        sample_pct = PCT_W'(pct);
        ev_cnt     = 0;
        for (int c = 0; c < raw_len * per; c++) begin
            @(negedge clk);
            if (c == 0) e0 = cyc + 1;
            rx = raw_q[c / per];
            if (c == 2 * per && alt > 0) bit_cycles = CYC_W'(alt);
        end
        @(negedge clk);
        rx      = 1'b1;
        restart = 1'b1;
        @(negedge clk);
        restart    = 1'b0;
        bit_cycles = CYC_W'(per);
        repeat (3 * per + 4) @(negedge clk);
    endtask

    // Reference model built from the timing and destuffing requirements.
    task automatic check_frame(input int per, input int pct, input string tag);
        int  off;
        int  idx;
        bit  stf;
        bit  same;
        off = (per * pct) / 100;
        if (off == 0) off = 1;
        idx = 0;
        check(ev_cnt == raw_len, {tag, " R9 event count"}, ev_cnt, raw_len);
        for (int n = 0; n < raw_len && n < ev_cnt; n++) begin
            same = 1'b1;
            for (int k = 2; k <= 5; k++) if (n >= 5 && raw_q[n-k] != raw_q[n-1]) same = 1'b0;
            stf = (n >= 5) && same && (raw_q[n] != raw_q[n-1]);
            check(ev_stuff[n] == stf, {tag, " R6 stuff flag"}, int'(ev_stuff[n]), int'(stf));
            check(ev_edge[n] == e0 + n * per + off, {tag, " R3 sample edge"},
                  ev_edge[n], e0 + n * per + off);
            if (!stf) begin
                check(ev_val[n] == raw_q[n], {tag, " R8 bit value"}, int'(ev_val[n]), int'(raw_q[n]));
                check(ev_idx[n] == idx, {tag, " R8 bit index"}, ev_idx[n], idx);
                idx++;
            end
        end
    endtask

    task automatic t_reset();
        check(bit_valid_o == 1'b0, "R10 valid in reset", int'(bit_valid_o), 0);
        check(stuff_o == 1'b0, "R10 stuff in reset", int'(stuff_o), 0);
        check(bit_value_o == 1'b0, "R10 value in reset", int'(bit_value_o), 0);
        check(bit_index_o == '0, "R10 index in reset", int'(bit_index_o), 0);
    endtask

    task automatic t_idle();
        ev_cnt = 0;
        rx = 1'b1;
        repeat (60) @(negedge clk);
        check(ev_cnt == 0, "R1 recessive idle output", ev_cnt, 0);
        restart = 1'b1;
        rx = 1'b0;
        repeat (10) @(negedge clk);
        rx = 1'b1;
        restart = 1'b0;
        repeat (40) @(negedge clk);
        check(ev_cnt == 0, "R2 restart blocks start", ev_cnt, 0);
    endtask

    task automatic t_plain();
        load(32'b0101100110, 10);
        run_frame(10, 70, 0);
        check_frame(10, 70, "plain");
    endtask

    task automatic t_stuff();
        // Stuff at raw 5; the stuff bit starts the run that makes raw 10 a stuff bit (R7).
        load(32'b0000011111010, 13);
        run_frame(8, 50, 0);
        check_frame(8, 50, "R7 stuff chain");
        check(ev_cnt > 10 && ev_stuff[10] == 1'b1, "R7 second stuff", int'(ev_stuff[10]), 1);
        // Six equal samples are data, not stuff (R6).
        load(32'b00000001010, 11);
        run_frame(6, 70, 0);
        check_frame(6, 70, "R6 six zeros");
    endtask

    task automatic t_rates();
        load(32'b011010011, 9);
        run_frame(13, 87, 0);
        check_frame(13, 87, "R4 p13");
        run_frame(7, 50, 0);
        check_frame(7, 50, "R4 p7");
        run_frame(3, 10, 0);
        check_frame(3, 10, "R4 clamp");
    endtask

    task automatic t_latch();
        load(32'b01101001101, 11);
        run_frame(10, 60, 4);
        check_frame(10, 60, "R5 latched period");
    endtask

    task automatic t_restart();
        load(32'b0110000, 7);
        run_frame(5, 60, 0);
        check_frame(5, 60, "R9 frame A");
        // With stale history 0000, the samples 0 then 1 would form 000001.
        load(32'b0101, 4);
        run_frame(5, 60, 0);
        check_frame(5, 60, "R9 frame B");
        check(ev_cnt > 0 && ev_stuff[1] == 1'b0, "R9 history cleared", int'(ev_stuff[1]), 0);
    endtask

    initial begin
        #800000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        rx         = 1'b1;
        restart    = 1'b0;
        bit_cycles = CYC_W'(10);
        sample_pct = PCT_W'(70);
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_idle();
        t_plain();
        t_stuff();
        t_rates();
        t_latch();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule